// File: doc/BRIEF.md
# Registered 8-bit ALU with Status Flags

This block is the arithmetic and logic stage of a small accumulator-style processor. Each cycle it can accept one operation. The inputs are a 5-bit operation code, a register operand (the accumulator or an index register), a memory operand and the current flag byte. One clock edge later it returns the result byte, the new flag byte and a write-enable. The write-enable tells the register file whether to keep the result.

Each operation changes only its own set of flags. All other flag bits, including the two unused bits of the flag byte, pass through unchanged. Subtraction treats the inverted carry as a borrow. Compare and bit test update flags but never request a register write. The decimal flag is carried through the block and has no effect on arithmetic.

The flag byte layout is fixed: N = bit 7, V = bit 6, bits 5:4 unused, D = bit 3, I = bit 2, Z = bit 1, C = bit 0.

The operation codes are: 0 NOP, 1 ADD, 2 SUB, 3 CMP, 4 BIT, 5 AND, 6 OR, 7 XOR, 8 SHL, 9 SHR, 10 ROL, 11 ROR, 12 INC, 13 DEC, 14 PASS, 15 SETC, 16 CLRC, 17 SETD, 18 CLRD, 19 SETI, 20 CLRI, 21 CLRV. Codes 22 to 31 are unused.

Top module: `alu8_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `wr_en_o`, `result_o` and `flags_o` are all zero.
- R2: ADD (code 1) produces reg + mem + C as its result, with C taken from flag bit 0. The carry out sets C. V is set when both operands have the same sign and the result's sign differs. N is bit 7 of the result, and Z is set when the result is zero. The write-enable is 1.
- R3: SUB (code 2) produces reg − mem − (1 − C). C is set when no borrow occurs. V follows the ADD rule applied to the complemented memory operand. N and Z are updated and the write-enable is 1.
- R4: CMP (code 3) forms reg − mem. It sets C when reg ≥ mem as unsigned values, and sets N and Z from the difference. V is left unchanged. The write-enable is 0 and `result_o` equals the register operand.
- R5: BIT (code 4) sets Z when (reg AND mem) is zero. N takes bit 7 of mem and V takes bit 6 of mem. The write-enable is 0 and `result_o` equals the register operand.
- R6: AND, OR, XOR, INC and DEC act on the register operand. PASS (code 14) copies the memory operand, which serves loads and transfers. All six update only N and Z and set the write-enable to 1.
- R7: SHL (code 8) moves bit 7 into C and fills bit 0 with 0. SHR (code 9) moves bit 0 into C and fills bit 7 with 0. Both act on the register operand and update N and Z. The write-enable is 1.
- R8: ROL (code 10) feeds the old C into bit 0, and ROR (code 11) feeds the old C into bit 7. The bit shifted out becomes the new C. Both update N and Z, and the write-enable is 1.
- R9: Codes 15 to 21 each force exactly one flag: set C, clear C, set D, clear D, set I, clear I, clear V. All other flag bits are unchanged, the write-enable is 0 and `result_o` equals the register operand.
- R10: Flag bits 5:4 always pass through unchanged. D passes through unchanged except under codes 17 and 18. The state of D does not change the result of ADD or SUB.
- R11: NOP (code 0) and the unused codes 22 to 31 leave the flag byte unchanged, give a write-enable of 0 and return the register operand.
- R12: Outputs appear exactly one clock after the inputs are sampled. `out_valid` follows `in_valid` with that one-cycle delay, and `wr_en_o` is 0 whenever `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request this cycle |
| op_i | input | 5 | Operation code |
| reg_i | input | 8 | Register operand (accumulator or index) |
| mem_i | input | 8 | Memory or immediate operand |
| flags_i | input | 8 | Current flag byte |
| out_valid | output | 1 | Registered result is valid |
| result_o | output | 8 | Result byte |
| flags_o | output | 8 | Updated flag byte |
| wr_en_o | output | 1 | Keep the result in the register file |

## Verification
The signed-overflow boundaries are the hardest cases to reach: V must flip exactly where a sum or difference crosses from +127 to −128. Carry-in and borrow add a third input, which the overflow decision also depends on. Random operands seldom land on these edges. The stimulus therefore opens with directed operand pairs placed right at the sign boundaries, with carry both set and clear. It then runs a long random stream, judged by a reference model that computes overflow from signed integer ranges instead of sign bits.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [4:0] {
        OP_NOP  = 5'd0,
        OP_ADD  = 5'd1,
        OP_SUB  = 5'd2,
        OP_CMP  = 5'd3,
        OP_BIT  = 5'd4,
        OP_AND  = 5'd5,
        OP_OR   = 5'd6,
        OP_XOR  = 5'd7,
        OP_SHL  = 5'd8,
        OP_SHR  = 5'd9,
        OP_ROL  = 5'd10,
        OP_ROR  = 5'd11,
        OP_INC  = 5'd12,
        OP_DEC  = 5'd13,
        OP_PASS = 5'd14,
        OP_SETC = 5'd15,
        OP_CLRC = 5'd16,
        OP_SETD = 5'd17,
        OP_CLRD = 5'd18,
        OP_SETI = 5'd19,
        OP_CLRI = 5'd20,
        OP_CLRV = 5'd21
    } alu_op_e;

    localparam int FLAG_W = 8;
    localparam int FB_C   = 0;
    localparam int FB_Z   = 1;
    localparam int FB_I   = 2;
    localparam int FB_D   = 3;
    localparam int FB_V   = 6;
    localparam int FB_N   = 7;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [4:0]        op_i,
    input  logic [DW-1:0]     a_i,
    input  logic [DW-1:0]     m_i,
    input  logic [FLAG_W-1:0] f_i,
    output logic [DW-1:0]     res_o,
    output logic [FLAG_W-1:0] f_o,
    output logic              wr_o,
    output logic              sel_o
);
    localparam int MSB = DW - 1;

    logic [DW-1:0] opnd;
    logic          cin;
    logic [DW:0]   sum;
    logic [DW-1:0] step;

    always_comb begin
        opnd = (op_i == OP_ADD) ? m_i : ~m_i;
        cin  = (op_i == OP_CMP) ? 1'b1 : f_i[FB_C];
        sum  = {1'b0, a_i} + {1'b0, opnd} + {{DW{1'b0}}, cin};
        step = (op_i == OP_INC) ? a_i + 1'b1 : a_i - 1'b1;

        res_o = a_i;
        f_o   = f_i;
        wr_o  = 1'b0;
        sel_o = 1'b0;
        case (op_i)
            OP_ADD, OP_SUB: begin
                res_o       = sum[MSB:0];
                f_o[FB_C]   = sum[DW];
                f_o[FB_V]   = (a_i[MSB] == opnd[MSB]) && (sum[MSB] != a_i[MSB]);
                f_o[FB_N]   = sum[MSB];
                f_o[FB_Z]   = (sum[MSB:0] == '0);
                wr_o        = 1'b1;
                sel_o       = 1'b1;
            end
            OP_CMP: begin
                f_o[FB_C]   = sum[DW];
                f_o[FB_N]   = sum[MSB];
                f_o[FB_Z]   = (sum[MSB:0] == '0);
                sel_o       = 1'b1;
            end
            OP_INC, OP_DEC: begin
                res_o       = step;
                f_o[FB_N]   = step[MSB];
                f_o[FB_Z]   = (step == '0);
                wr_o        = 1'b1;
                sel_o       = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [4:0]        op_i,
    input  logic [DW-1:0]     a_i,
    input  logic [DW-1:0]     m_i,
    input  logic [FLAG_W-1:0] f_i,
    output logic [DW-1:0]     res_o,
    output logic [FLAG_W-1:0] f_o,
    output logic              wr_o,
    output logic              sel_o
);
    localparam int MSB = DW - 1;

    logic [DW-1:0] val;

    always_comb begin
        case (op_i)
            OP_OR:   val = a_i | m_i;
            OP_XOR:  val = a_i ^ m_i;
            OP_PASS: val = m_i;
            default: val = a_i & m_i;
        endcase

        res_o = a_i;
        f_o   = f_i;
        wr_o  = 1'b0;
        sel_o = 1'b0;
        case (op_i)
            OP_AND, OP_OR, OP_XOR, OP_PASS: begin
                res_o     = val;
                f_o[FB_N] = val[MSB];
                f_o[FB_Z] = (val == '0);
                wr_o      = 1'b1;
                sel_o     = 1'b1;
            end
            OP_BIT: begin
                f_o[FB_Z] = (val == '0);
                f_o[FB_N] = m_i[MSB];
                f_o[FB_V] = m_i[MSB-1];
                sel_o     = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [4:0]        op_i,
    input  logic [DW-1:0]     a_i,
    input  logic [FLAG_W-1:0] f_i,
    output logic [DW-1:0]     res_o,
    output logic [FLAG_W-1:0] f_o,
    output logic              wr_o,
    output logic              sel_o
);
    localparam int MSB = DW - 1;

    logic          left;
    logic          fill;
    logic [DW-1:0] val;
    logic          out_bit;

    always_comb begin
        left    = (op_i == OP_SHL) || (op_i == OP_ROL);
        fill    = ((op_i == OP_ROL) || (op_i == OP_ROR)) ? f_i[FB_C] : 1'b0;
        val     = left ? {a_i[MSB-1:0], fill} : {fill, a_i[MSB:1]};
        out_bit = left ? a_i[MSB] : a_i[0];

        res_o = a_i;
        f_o   = f_i;
        wr_o  = 1'b0;
        sel_o = 1'b0;
        case (op_i)
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                res_o     = val;
                f_o[FB_C] = out_bit;
                f_o[FB_N] = val[MSB];
                f_o[FB_Z] = (val == '0);
                wr_o      = 1'b1;
                sel_o     = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_unit.sv
module alu8_unit
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [4:0]        op_i,
    input  logic [DW-1:0]     reg_i,
    input  logic [DW-1:0]     mem_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic              out_valid,
    output logic [DW-1:0]     result_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic              wr_en_o
);
    typedef struct packed {
        logic              vld;
        logic              wr;
        logic [DW-1:0]     res;
        logic [FLAG_W-1:0] flg;
    } stage_t;

    stage_t st_d, st_q;

    logic [DW-1:0]     ar_res, lg_res, sh_res;
    logic [FLAG_W-1:0] ar_f, lg_f, sh_f;
    logic              ar_wr, lg_wr, sh_wr;
    logic              ar_sel, lg_sel, sh_sel;

    alu8_arith #(.DW(DW)) u_arith (
        .op_i(op_i), .a_i(reg_i), .m_i(mem_i), .f_i(flags_i),
        .res_o(ar_res), .f_o(ar_f), .wr_o(ar_wr), .sel_o(ar_sel)
    );

    alu8_logic #(.DW(DW)) u_logic (
        .op_i(op_i), .a_i(reg_i), .m_i(mem_i), .f_i(flags_i),
        .res_o(lg_res), .f_o(lg_f), .wr_o(lg_wr), .sel_o(lg_sel)
    );

    alu8_shift #(.DW(DW)) u_shift (
        .op_i(op_i), .a_i(reg_i), .f_i(flags_i),
        .res_o(sh_res), .f_o(sh_f), .wr_o(sh_wr), .sel_o(sh_sel)
    );

    always_comb begin
        st_d.vld = in_valid;
        st_d.wr  = 1'b0;
        st_d.res = reg_i;
        st_d.flg = flags_i;
        if (ar_sel) begin
            st_d.wr = ar_wr; st_d.res = ar_res; st_d.flg = ar_f;
        end else if (lg_sel) begin
            st_d.wr = lg_wr; st_d.res = lg_res; st_d.flg = lg_f;
        end else if (sh_sel) begin
            st_d.wr = sh_wr; st_d.res = sh_res; st_d.flg = sh_f;
        end else begin
            case (op_i)
                OP_SETC: st_d.flg[FB_C] = 1'b1;
                OP_CLRC: st_d.flg[FB_C] = 1'b0;
                OP_SETD: st_d.flg[FB_D] = 1'b1;
                OP_CLRD: st_d.flg[FB_D] = 1'b0;
                OP_SETI: st_d.flg[FB_I] = 1'b1;
                OP_CLRI: st_d.flg[FB_I] = 1'b0;
                OP_CLRV: st_d.flg[FB_V] = 1'b0;
                default: ;
            endcase
        end
        st_d.wr = st_d.wr & in_valid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result_o  = st_q.res;
    assign flags_o   = st_q.flg;
    assign wr_en_o   = st_q.wr;

    // R2: carry out and result together equal the full sum
    assert_add_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_i == OP_ADD) |=>
        ({flags_o[FB_C], result_o} == ({1'b0, $past(reg_i)} + {1'b0, $past(mem_i)}
                                      + {{DW{1'b0}}, $past(flags_i[FB_C])})));

    // R4: compare never writes and keeps V
    assert_cmp_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_i == OP_CMP) |=>
        (!wr_en_o && result_o == $past(reg_i) && flags_o[FB_V] == $past(flags_i[FB_V])));

    // R8: rotate-left feeds the old carry into bit 0
    assert_rol_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_i == OP_ROL) |=> (result_o[0] == $past(flags_i[FB_C])));

    // R10: unused flag bits always pass through
    assert_spare_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (flags_o[5:4] == $past(flags_i[5:4])));

    // R9: set-carry changes only bit 0
    assert_setc_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_i == OP_SETC) |=> (flags_o == ($past(flags_i) | 8'h01)));

    // R12: a write is only requested alongside a valid output
    assert_wr_needs_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> out_valid);

    // R12: valid output is the delayed request
    assert_valid_delay_R12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
endmodule

// File: tb/alu8_unit_tb.sv
module alu8_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [4:0] op_i = '0;
    logic [7:0] reg_i = '0;
    logic [7:0] mem_i = '0;
    logic [7:0] flags_i = '0;
    logic       out_valid;
    logic [7:0] result_o;
    logic [7:0] flags_o;
    logic       wr_en_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    alu8_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_i(op_i),
        .reg_i(reg_i), .mem_i(mem_i), .flags_i(flags_i),
        .out_valid(out_valid), .result_o(result_o), .flags_o(flags_o), .wr_en_o(wr_en_o)
    );

    function automatic int put_bit(int f, int pos, int v);
        return (f & ~(1 << pos)) | ((v != 0 ? 1 : 0) << pos);
    endfunction

    function automatic int sgn(int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    // returns {wr, res[7:0], flags[7:0]} as an integer
    function automatic int model(int op, int a, int m, int f);
        int r = a, nf = f, wr = 0, c = f & 1, t, s;
        bit nz = 0;
        case (op)
            1: begin t = a + m + c; r = t % 256; s = sgn(a) + sgn(m) + c;
                nf = put_bit(nf, 0, t > 255); nf = put_bit(nf, 6, s > 127 || s < -128);
                nz = 1; wr = 1; end
            2: begin t = a - m - (1 - c); r = (t + 512) % 256; s = sgn(a) - sgn(m) - (1 - c);
                nf = put_bit(nf, 0, t >= 0); nf = put_bit(nf, 6, s > 127 || s < -128);
                nz = 1; wr = 1; end
            3: begin t = (a - m + 256) % 256; nf = put_bit(nf, 0, a >= m);
                nf = put_bit(nf, 7, t >= 128); nf = put_bit(nf, 1, t == 0); end
            4: begin nf = put_bit(nf, 1, (a & m) == 0); nf = put_bit(nf, 7, m >= 128);
                nf = put_bit(nf, 6, (m / 64) % 2); end
            5: begin r = a & m; nz = 1; wr = 1; end
            6: begin r = a | m; nz = 1; wr = 1; end
            7: begin r = a ^ m; nz = 1; wr = 1; end
            8: begin r = (a * 2) % 256; nf = put_bit(nf, 0, a >= 128); nz = 1; wr = 1; end
            9: begin r = a / 2; nf = put_bit(nf, 0, a % 2); nz = 1; wr = 1; end
            10: begin r = (a * 2) % 256 + c; nf = put_bit(nf, 0, a >= 128); nz = 1; wr = 1; end
            11: begin r = a / 2 + 128 * c; nf = put_bit(nf, 0, a % 2); nz = 1; wr = 1; end
            12: begin r = (a + 1) % 256; nz = 1; wr = 1; end
            13: begin r = (a + 255) % 256; nz = 1; wr = 1; end
            14: begin r = m; nz = 1; wr = 1; end
            15: nf = put_bit(nf, 0, 1);
            16: nf = put_bit(nf, 0, 0);
            17: nf = put_bit(nf, 3, 1);
            18: nf = put_bit(nf, 3, 0);
            19: nf = put_bit(nf, 2, 1);
            20: nf = put_bit(nf, 2, 0);
            21: nf = put_bit(nf, 6, 0);
            default: ;
        endcase
        if (nz) begin
            nf = put_bit(nf, 7, r >= 128);
            nf = put_bit(nf, 1, r == 0);
        end
        return (wr << 16) | (r << 8) | nf;
    endfunction

    function automatic string req_of(int op);
        case (op)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5, 6, 7, 12, 13, 14: return "R6";
            8, 9: return "R7";
            10, 11: return "R8";
            15, 16, 17, 18, 19, 20, 21: return "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one operation, wait one clock, compare the registered outputs
    task automatic run_op(int op, int a, int m, int f, string req);
        int e = model(op, a, m, f);
        in_valid = 1'b1; op_i = op[4:0]; reg_i = a[7:0]; mem_i = m[7:0]; flags_i = f[7:0];
        @(negedge clk);
        check(req, {15'd0, out_valid, wr_en_o, result_o, flags_o}, (1 << 17) | e);
    endtask

    initial begin : watchdog
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        int a0;
        int a1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {14'd0, out_valid, wr_en_o, result_o, flags_o}, 0);
        in_valid = 1'b1; op_i = 5'd1; reg_i = 8'hFF; mem_i = 8'hFF; flags_i = 8'hFF;
        @(negedge clk);
        check("R1", {14'd0, out_valid, wr_en_o, result_o, flags_o}, 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        // R12: no request gives no valid and no write
        check("R12", {30'd0, out_valid, wr_en_o}, 0);

        // R2 overflow boundaries
        run_op(1, 8'h50, 8'h50, 8'h00, "R2");
        run_op(1, 8'h7F, 8'h00, 8'h01, "R2");
        run_op(1, 8'hFF, 8'h00, 8'h01, "R2");
        run_op(1, 8'h80, 8'h80, 8'h00, "R2");
        // R3 borrow and overflow
        run_op(2, 8'h50, 8'hF0, 8'h01, "R3");
        run_op(2, 8'h80, 8'h01, 8'h01, "R3");
        run_op(2, 8'h00, 8'h00, 8'h00, "R3");
        run_op(2, 8'h7F, 8'hFF, 8'h01, "R3");
        // R4 compare equal, less, greater
        run_op(3, 8'h40, 8'h40, 8'h40, "R4");
        run_op(3, 8'h10, 8'h20, 8'h00, "R4");
        run_op(3, 8'hF0, 8'h01, 8'hC0, "R4");
        // R5 bit test
        run_op(4, 8'h0F, 8'hC0, 8'h00, "R5");
        run_op(4, 8'h01, 8'h41, 8'h82, "R5");
        // R6 logic, inc, dec, pass
        run_op(5, 8'hF0, 8'h0F, 8'h41, "R6");
        run_op(12, 8'hFF, 8'h00, 8'h41, "R6");
        run_op(13, 8'h00, 8'h00, 8'h00, "R6");
        run_op(14, 8'h00, 8'h80, 8'h02, "R6");
        // R7 shifts
        run_op(8, 8'h81, 8'h00, 8'h00, "R7");
        run_op(9, 8'h01, 8'h00, 8'h80, "R7");
        // R8 rotates with C set and clear
        run_op(10, 8'h80, 8'h00, 8'h01, "R8");
        run_op(11, 8'h01, 8'h00, 8'h01, "R8");
        run_op(11, 8'h00, 8'h00, 8'h00, "R8");
        // R9 each set/clear
        for (int k = 15; k <= 21; k++) begin
            run_op(k, 8'h5A, 8'h00, 8'h00, "R9");
            run_op(k, 8'h5A, 8'h00, 8'hFF, "R9");
        end
        // R10: D flag does not change the sum, bits 5:4 kept
        run_op(1, 8'h19, 8'h28, 8'h39, "R10");
        a0 = result_o;
        run_op(1, 8'h19, 8'h28, 8'h31, "R10");
        a1 = result_o;
        check("R10", a0, a1);
        // R11: NOP and unused codes
        run_op(0, 8'h33, 8'h44, 8'hA5, "R11");
        run_op(31, 8'h33, 8'h44, 8'h5A, "R11");
        // R12: drop request between operations
        in_valid = 1'b0;
        @(negedge clk);
        check("R12", {30'd0, out_valid, wr_en_o}, 0);

        for (int i = 0; i < 4000; i++) begin
            int op = $urandom_range(0, 31);
            run_op(op, $urandom_range(0, 255), $urandom_range(0, 255),
                   $urandom_range(0, 255), req_of(op));
        end

        in_valid = 1'b0;
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule